// File: doc/BRIEF.md
# Sigmoid and Tanh Spline Coefficient Unit

This block supplies the coefficients for a piecewise-linear approximation of the logistic sigmoid and of the hyperbolic tangent on a 16-bit two's complement input with 12 fractional bits (range -8.0 to just under 8.0). Each accepted input gets a slope, the position inside its segment and an offset. For convenience the block also forms slope times fraction plus offset, so the approximated function value can be read directly.

Only one 16-entry sigmoid segment table exists. Tanh coefficients are derived from it through the identity tanh(x) = 2·sigmoid(2x) − 1. The doubled input picks the segment, with saturation when 2x leaves the table's range. The slope is doubled, and the offset 2β − 1 is built by rewiring bits, not by an adder. An input is accepted when its valid bit is high. A function-select bit picks sigmoid or tanh. All outputs are registered and appear one clock later, together with a delayed valid.

Top module: `act_coef_unit`

## Requirements
- R1: While reset is asserted, and right after it, out_valid is 0 and out_slope, out_frac, out_offset and out_y are all 0.
- R2: With in_func = 0 (sigmoid), let k be the signed value of in_x[15:12]. Then out_frac = in_x[11:0], out_offset = B(k) zero-extended, and out_slope = B(k+1) − B(k). Here B(j) = round(4096·sigmoid(j)) for j from −8 to 8.
- R3: With in_func = 1 (tanh) and in_x[15:14] equal to 00 or 11, the segment is the signed value of in_x[14:11]. out_frac = {in_x[10:0], 0}, and out_slope is twice the sigmoid slope of that segment.
- R4: With in_func = 1 and in_x[15:14] = 01 (2x overflows upward), segment 7 is used and out_frac = 4095.
- R5: With in_func = 1 and in_x[15:14] = 10 (2x overflows downward), segment −8 (code 1000) is used and out_frac = 0.
- R6: In tanh mode, out_offset is 2·B(k) − 4096 as a 13-bit two's complement value, for the segment k selected by R3 to R5.
- R7: out_y equals floor((out_slope·out_frac + 2048) / 4096) + signed(out_offset), clamped to the signed 16-bit range.
- R8: out_valid is in_valid delayed by one clock, and the data of an accepted input appear on the clock edge after it is sampled.
- R9: When in_valid is 0, out_slope, out_frac, out_offset and out_y keep their previous values whatever in_x and in_func carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is present |
| in_func | input | 1 | 0 = sigmoid, 1 = tanh |
| in_x | input | 16 | Input, two's complement, 12 fractional bits |
| out_valid | output | 1 | Registered copy of in_valid |
| out_slope | output | 13 | Segment slope, unsigned, 12 fractional bits |
| out_frac | output | 12 | Position inside the segment, unsigned fraction |
| out_offset | output | 13 | Segment offset, two's complement, 12 fractional bits |
| out_y | output | 16 | Evaluated function, two's complement, 12 fractional bits, saturated |

## Verification
The bench uses the default widths: a 16-bit input, 12 fractional bits and a 4-bit segment index. This is small enough to drive every one of the 65536 input codes through both functions, one per clock. The sweep therefore reaches every segment boundary, every code in both tanh overflow bands, and every offset that the bit rewiring can produce. The expected values come from the bench's own table, which it builds with the exponential function, and from integer arithmetic on the doubled input. Short idle stretches with changing inputs then test that the outputs hold and that valid is delayed by one clock.

// File: rtl/actc_pkg.sv
`timescale 1ns/1ps
package actc_pkg;

    localparam int ACTC_DATA_W = 16;
    localparam int ACTC_FRAC_W = 12;
    localparam int ACTC_KNOT_W = ACTC_DATA_W - ACTC_FRAC_W;

    typedef enum logic {
        ACT_SIGMOID = 1'b0,
        ACT_TANH    = 1'b1
    } act_func_e;

    typedef struct packed {
        logic [ACTC_FRAC_W-1:0] slope;
        logic [ACTC_FRAC_W-1:0] offset;
    } seg_coef_t;

    // Segment coefficients for sigmoid in Q0.12. The knot code is the signed
    // segment start: 0..7 cover [0,8), 8..15 cover [-8,0).
    function automatic seg_coef_t seg_lookup(input logic [ACTC_KNOT_W-1:0] knot);
        seg_coef_t c;
        unique case (knot)
            4'd0:  c = '{slope: 12'd946, offset: 12'd2048};
            4'd1:  c = '{slope: 12'd614, offset: 12'd2994};
            4'd2:  c = '{slope: 12'd294, offset: 12'd3608};
            4'd3:  c = '{slope: 12'd120, offset: 12'd3902};
            4'd4:  c = '{slope: 12'd47,  offset: 12'd4022};
            4'd5:  c = '{slope: 12'd17,  offset: 12'd4069};
            4'd6:  c = '{slope: 12'd6,   offset: 12'd4086};
            4'd7:  c = '{slope: 12'd3,   offset: 12'd4092};
            4'd8:  c = '{slope: 12'd3,   offset: 12'd1};
            4'd9:  c = '{slope: 12'd6,   offset: 12'd4};
            4'd10: c = '{slope: 12'd17,  offset: 12'd10};
            4'd11: c = '{slope: 12'd47,  offset: 12'd27};
            4'd12: c = '{slope: 12'd120, offset: 12'd74};
            4'd13: c = '{slope: 12'd294, offset: 12'd194};
            4'd14: c = '{slope: 12'd614, offset: 12'd488};
            4'd15: c = '{slope: 12'd946, offset: 12'd1102};
            default: c = '{slope: 12'd0, offset: 12'd0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/actc_index_sel.sv
`timescale 1ns/1ps
module actc_index_sel
    import actc_pkg::*;
#(
    parameter int DATA_W = ACTC_DATA_W,
    parameter int FRAC_W = ACTC_FRAC_W,
    parameter int KNOT_W = ACTC_KNOT_W
) (
    input  logic [DATA_W-1:0] x,
    input  act_func_e         fsel,
    output logic [KNOT_W-1:0] knot,
    output logic [FRAC_W-1:0] frac
);
    localparam int MSB = DATA_W - 1;
    localparam logic [KNOT_W-1:0] KNOT_TOP = {1'b0, {(KNOT_W-1){1'b1}}};
    localparam logic [KNOT_W-1:0] KNOT_BOT = {1'b1, {(KNOT_W-1){1'b0}}};

    always_comb begin
        knot = x[MSB -: KNOT_W];
        frac = x[FRAC_W-1:0];
        unique case (fsel)
            ACT_SIGMOID: begin
                knot = x[MSB -: KNOT_W];
                frac = x[FRAC_W-1:0];
            end
            ACT_TANH: begin
                unique case (x[MSB -: 2])
                    2'b01: begin
                        knot = KNOT_TOP;
                        frac = '1;
                    end
                    2'b10: begin
                        knot = KNOT_BOT;
                        frac = '0;
                    end
                    default: begin
                        knot = x[MSB-1 -: KNOT_W];
                        frac = {x[FRAC_W-2:0], 1'b0};
                    end
                endcase
            end
            default: begin
                knot = x[MSB -: KNOT_W];
                frac = x[FRAC_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/actc_seg_table.sv
`timescale 1ns/1ps
module actc_seg_table
    import actc_pkg::*;
#(
    parameter int FRAC_W = ACTC_FRAC_W,
    parameter int KNOT_W = ACTC_KNOT_W
) (
    input  logic [KNOT_W-1:0] knot,
    output logic [FRAC_W-1:0] alpha,
    output logic [FRAC_W-1:0] beta
);
    seg_coef_t coef;

    always_comb begin
        coef  = seg_lookup(knot);
        alpha = coef.slope;
        beta  = coef.offset;
    end

endmodule

// File: rtl/actc_tanh_adjust.sv
`timescale 1ns/1ps
module actc_tanh_adjust
    import actc_pkg::*;
#(
    parameter int FRAC_W = ACTC_FRAC_W
) (
    input  act_func_e         fsel,
    input  logic [FRAC_W-1:0] alpha,
    input  logic [FRAC_W-1:0] beta,
    output logic [FRAC_W:0]   slope,
    output logic [FRAC_W:0]   offset
);
    always_comb begin
        slope  = {1'b0, alpha};
        offset = {1'b0, beta};
        unique case (fsel)
            ACT_SIGMOID: begin
                slope  = {1'b0, alpha};
                offset = {1'b0, beta};
            end
            ACT_TANH: begin
                // 2*beta - 1 with beta in [0,1): invert the top bit, shift left.
                slope  = {alpha, 1'b0};
                offset = {~beta[FRAC_W-1], beta[FRAC_W-2:0], 1'b0};
            end
            default: begin
                slope  = {1'b0, alpha};
                offset = {1'b0, beta};
            end
        endcase
    end

endmodule

// File: rtl/actc_spline_mac.sv
`timescale 1ns/1ps
module actc_spline_mac
    import actc_pkg::*;
#(
    parameter int DATA_W = ACTC_DATA_W,
    parameter int FRAC_W = ACTC_FRAC_W
) (
    input  logic [FRAC_W:0]   slope,
    input  logic [FRAC_W-1:0] frac,
    input  logic [FRAC_W:0]   offset,
    output logic [DATA_W-1:0] y
);
    localparam int SLOPE_W = FRAC_W + 1;
    localparam int PROD_W  = SLOPE_W + FRAC_W;
    localparam int SUM_W   = PROD_W + 2;
    localparam logic [PROD_W:0] HALF_LSB = (PROD_W+1)'(1) << (FRAC_W - 1);
    localparam logic signed [SUM_W-1:0] Y_MAX = SUM_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] Y_MIN = -Y_MAX - SUM_W'(1);

    logic [PROD_W-1:0]        prod;
    logic [PROD_W:0]          rnd;
    logic signed [SUM_W-1:0]  scaled;
    logic signed [SUM_W-1:0]  off_ext;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        prod    = PROD_W'(slope) * PROD_W'(frac);
        rnd     = {1'b0, prod} + HALF_LSB;
        scaled  = signed'(SUM_W'(rnd[PROD_W:FRAC_W]));
        off_ext = SUM_W'($signed(offset));
        sum     = scaled + off_ext;
        if (sum > Y_MAX) begin
            y = Y_MAX[DATA_W-1:0];
        end else if (sum < Y_MIN) begin
            y = Y_MIN[DATA_W-1:0];
        end else begin
            y = sum[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/act_coef_unit.sv
`timescale 1ns/1ps
module act_coef_unit
    import actc_pkg::*;
#(
    parameter int DATA_W = ACTC_DATA_W,
    parameter int FRAC_W = ACTC_FRAC_W,
    parameter int KNOT_W = DATA_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_func,
    input  logic [DATA_W-1:0] in_x,
    output logic              out_valid,
    output logic [FRAC_W:0]   out_slope,
    output logic [FRAC_W-1:0] out_frac,
    output logic [FRAC_W:0]   out_offset,
    output logic [DATA_W-1:0] out_y
);
    act_func_e         fsel;
    logic [KNOT_W-1:0] knot;
    logic [FRAC_W-1:0] frac_c;
    logic [FRAC_W-1:0] alpha;
    logic [FRAC_W-1:0] beta;
    logic [FRAC_W:0]   slope_c;
    logic [FRAC_W:0]   offset_c;
    logic [DATA_W-1:0] y_c;

    assign fsel = act_func_e'(in_func);

    actc_index_sel #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .KNOT_W(KNOT_W)) u_idx (
        .x    (in_x),
        .fsel (fsel),
        .knot (knot),
        .frac (frac_c)
    );

    actc_seg_table #(.FRAC_W(FRAC_W), .KNOT_W(KNOT_W)) u_tab (
        .knot  (knot),
        .alpha (alpha),
        .beta  (beta)
    );

    actc_tanh_adjust #(.FRAC_W(FRAC_W)) u_adj (
        .fsel   (fsel),
        .alpha  (alpha),
        .beta   (beta),
        .slope  (slope_c),
        .offset (offset_c)
    );

    actc_spline_mac #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mac (
        .slope  (slope_c),
        .frac   (frac_c),
        .offset (offset_c),
        .y      (y_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_slope  <= '0;
            out_frac   <= '0;
            out_offset <= '0;
            out_y      <= '0;
        end else if (in_valid) begin
            out_slope  <= slope_c;
            out_frac   <= frac_c;
            out_offset <= offset_c;
            out_y      <= y_c;
        end
    end

endmodule

// File: rtl/act_coef_unit_chk.sv
`timescale 1ns/1ps
module act_coef_unit_chk #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_func,
    input logic [DATA_W-1:0] in_x,
    input logic              out_valid,
    input logic [FRAC_W:0]   out_slope,
    input logic [FRAC_W-1:0] out_frac,
    input logic [FRAC_W:0]   out_offset,
    input logic [DATA_W-1:0] out_y
);
    localparam int MSB = DATA_W - 1;
    localparam int Y_BOUND = 1 << FRAC_W;

    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_slope) && $stable(out_frac)
                       && $stable(out_offset) && $stable(out_y)));

    a_r2_sigmoid_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_func) |=>
            (out_frac == $past(in_x[FRAC_W-1:0]) && !out_offset[FRAC_W]));

    a_r4_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func && in_x[MSB -: 2] == 2'b01) |=> (out_frac == '1));

    a_r5_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func && in_x[MSB -: 2] == 2'b10) |=> (out_frac == '0));

    a_r6_tanh_offset_even: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func) |=> !out_offset[0]);

    a_r7_y_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_y) <= Y_BOUND && $signed(out_y) >= -Y_BOUND));

endmodule

bind act_coef_unit act_coef_unit_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_func    (in_func),
    .in_x       (in_x),
    .out_valid  (out_valid),
    .out_slope  (out_slope),
    .out_frac   (out_frac),
    .out_offset (out_offset),
    .out_y      (out_y)
);

// File: tb/act_coef_unit_tb.sv
`timescale 1ns/1ps
module act_coef_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_func = 1'b0;
    logic [15:0] in_x = '0;
    logic        out_valid;
    logic [12:0] out_slope;
    logic [11:0] out_frac;
    logic [12:0] out_offset;
    logic [15:0] out_y;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    int bet [0:16];
    int alp [0:15];

    int    e_slope, e_frac, e_off, e_y;
    string e_tag;
    bit    have_prev = 0;

    always #10 clk = ~clk;

    act_coef_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_func    (in_func),
        .in_x       (in_x),
        .out_valid  (out_valid),
        .out_slope  (out_slope),
        .out_frac   (out_frac),
        .out_offset (out_offset),
        .out_y      (out_y)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic calc(input bit f, input logic [15:0] xv);
        int xs, t, k, fr, sl, of, y;
        xs = int'($signed(xv));
        if (!f) begin
            k  = xs >>> 12;
            fr = xs - k * 4096;
            sl = alp[k + 8];
            of = bet[k + 8];
            e_tag = "R2";
        end else begin
            t = 2 * xs;
            if (t > 32767) begin
                k = 7; fr = 4095; e_tag = "R4";
            end else if (t < -32768) begin
                k = -8; fr = 0; e_tag = "R5";
            end else begin
                k = t >>> 12; fr = t - k * 4096; e_tag = "R3";
            end
            sl = 2 * alp[k + 8];
            of = 2 * bet[k + 8] - 4096;
        end
        y = ((sl * fr + 2048) >>> 12) + of;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        e_slope = sl; e_frac = fr; e_off = of; e_y = y;
    endtask

    task automatic check_outputs(input bit exp_valid);
        chk("R8", "out_valid", int'(out_valid), int'(exp_valid));
        chk(e_tag, "out_slope", int'(out_slope), e_slope);
        chk(e_tag, "out_frac", int'(out_frac), e_frac);
        chk((e_tag == "R2") ? "R2" : "R6", "out_offset", int'($signed(out_offset)), e_off);
        chk("R7", "out_y", int'($signed(out_y)), e_y);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        for (int i = 0; i <= 16; i++)
            bet[i] = $rtoi(4096.0 / (1.0 + $exp(-real'(i - 8))) + 0.5);
        for (int i = 0; i < 16; i++)
            alp[i] = bet[i + 1] - bet[i];

        // R1: reset state, with the input toggling
        repeat (3) @(negedge clk);
        in_valid = 1'b1; in_x = 16'h1234;
        @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        chk("R1", "out_slope in reset", int'(out_slope), 0);
        chk("R1", "out_frac in reset", int'(out_frac), 0);
        chk("R1", "out_offset in reset", int'(out_offset), 0);
        chk("R1", "out_y in reset", int'(out_y), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "out_y after reset", int'(out_y), 0);

        // Exhaustive sweep: sigmoid R2, tanh R3/R4/R5/R6, evaluation R7, timing R8
        for (int f = 0; f < 2; f++) begin
            for (int v = 0; v < 65536; v++) begin
                if (have_prev) check_outputs(1'b1);
                in_valid = 1'b1;
                in_func  = f[0];
                in_x     = v[15:0];
                calc(f[0], v[15:0]);
                have_prev = 1;
                @(negedge clk);
            end
        end
        check_outputs(1'b1);

        // R9: idle cycles with changing inputs leave the data unchanged
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b0;
            in_func  = i[0];
            in_x     = 16'h5A5A ^ 16'(i * 16'h1111);
            @(negedge clk);
            chk("R9", "out_slope hold", int'(out_slope), e_slope);
            chk("R9", "out_frac hold", int'(out_frac), e_frac);
            chk("R9", "out_offset hold", int'($signed(out_offset)), e_off);
            chk("R9", "out_y hold", int'($signed(out_y)), e_y);
            chk("R8", "out_valid idle", int'(out_valid), 0);
        end

        // R8: one accepted sample after idle, then idle again
        in_valid = 1'b1; in_func = 1'b0; in_x = 16'h0800;
        calc(1'b0, 16'h0800);
        @(negedge clk);
        check_outputs(1'b1);
        in_valid = 1'b0; in_x = 16'hC000;
        @(negedge clk);
        chk("R8", "out_valid drop", int'(out_valid), 0);
        chk("R9", "out_y after drop", int'($signed(out_y)), e_y);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule